// File: doc/BRIEF.md
# Strobed FIFO with Read-Pointer Rewind

This block is a first-in/first-out word buffer with a 9-bit path, so each 8-bit byte can carry a parity or control bit. A producer presents a one-cycle write strobe with a data word, and a consumer presents a one-cycle read strobe. Both strobes are sampled on a single system clock. Storage is addressed by two internal ring pointers, so neither side ever supplies an address. Three active-low status flags report the buffer state: empty, full and more-than-half-full. They let each side hold off before it overflows or underflows the buffer.

A rewind strobe moves the read pointer back to location zero and leaves the write pointer where it is. Everything written since reset can then be played out again, provided fewer than DEPTH words were written. The read port has a registered output enable that stands in for a tri-state bus. It is high only in the cycle after an accepted read, and the data lines are zero whenever it is low. DEPTH is a parameter and must be a power of two, at least 4.

Top module: `strobe_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted on the write port, and each word keeps all 9 bits.
- R2: While reset is applied, and just after it is released, empty_n is 0, full_n is 1, half_n is 1 and rd_oe is 0.
- R3: A write strobe sampled while full_n is 0 is ignored: no word is stored and the write pointer does not move.
- R4: A read strobe sampled while empty_n is 0 is ignored: rd_oe stays 0 and the read pointer does not move.
- R5: empty_n is 0 exactly when occupancy is zero. full_n is 0 exactly when occupancy equals DEPTH, so after reset with no reads it falls on the DEPTH-th write.
- R6: half_n falls on an accepted write that takes occupancy above DEPTH/2. Apart from a rewind (R7), only an accepted read that leaves occupancy at DEPTH/2 or below raises it again.
- R7: An accepted rewind sets the read pointer to zero and leaves the write pointer alone. Occupancy becomes the write pointer value, and all three flags are recomputed from it.
- R8: A rewind strobe in the same cycle as a write or read strobe is ignored; the other strobe still acts normally.
- R9: rd_oe is 1 only in the cycle after an accepted read, with that word on rd_data. In every other cycle rd_data is all zeros.
- R10: An accepted read and an accepted write in the same cycle leave occupancy and half_n unchanged.
- R11: A write into an empty buffer raises empty_n one cycle later. A read on that next cycle returns the word, and empty_n falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle write request |
| wr_data | input | WIDTH | Word to store |
| rd_stb | input | 1 | One-cycle read request |
| rt_stb | input | 1 | One-cycle rewind request |
| rd_data | output | WIDTH | Word read out; zero while rd_oe is low |
| rd_oe | output | 1 | Read data valid / bus drive enable |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
Each kind of internal fault shows up at the ports in a predictable way:

- **Write pointer off by one.** The read port returns a stale or overwritten word. This is seen on the first read that reaches the damaged slot, at most DEPTH reads later.
- **Occupancy count off by one.** The flags flip one operation early or late. The full and half thresholds expose this the moment occupancy crosses them.
- **Rewind moves the wrong pointer, or fires beside another strobe.** The very next read returns the wrong word.

The bench fills the buffer to every level from empty to full and applies each strobe combination there. It then drains the buffer and compares every flag and data cycle with an arithmetic model.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    // Operation applied to the pointers in one clock cycle.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_REWIND
    } fifo_op_e;

    function automatic fifo_op_e pick_op(logic push_ok, logic pop_ok, logic rewind_ok);
        fifo_op_e op;
        if (rewind_ok)                op = OP_REWIND;
        else if (push_ok && pop_ok)   op = OP_SWAP;
        else if (push_ok)             op = OP_PUSH;
        else if (pop_ok)              op = OP_POP;
        else                          op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/strobe_fifo_ram.sv
module strobe_fifo_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells_q[wr_addr] <= wr_word;
        end
    end

    assign rd_word = cells_q[rd_addr];

endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic          rt_stb,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          empty_n;
        logic          full_n;
        logic          half_n;
    } ctl_t;

    ctl_t     st_q, st_d;
    fifo_op_e op;

    always_comb begin
        op   = pick_op(wr_stb & st_q.full_n,
                       rd_stb & st_q.empty_n,
                       rt_stb & ~wr_stb & ~rd_stb);
        st_d = st_q;
        unique case (op)
            OP_PUSH: begin
                st_d.wp  = st_q.wp + 1'b1;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_d.cnt > CNT_HALF) st_d.half_n = 1'b0;
            end
            OP_POP: begin
                st_d.rp  = st_q.rp + 1'b1;
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_d.cnt <= CNT_HALF) st_d.half_n = 1'b1;
            end
            OP_SWAP: begin
                st_d.wp = st_q.wp + 1'b1;
                st_d.rp = st_q.rp + 1'b1;
            end
            OP_REWIND: begin
                st_d.rp     = '0;
                st_d.cnt    = {1'b0, st_q.wp};
                st_d.half_n = ~(st_d.cnt > CNT_HALF);
            end
            default: ;
        endcase
        st_d.empty_n = (st_d.cnt != '0);
        st_d.full_n  = (st_d.cnt != CNT_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wp: '0, rp: '0, cnt: '0, empty_n: 1'b0, full_n: 1'b1, half_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
    assign rd_en   = (op == OP_POP)  || (op == OP_SWAP);
    assign wr_addr = st_q.wp;
    assign rd_addr = st_q.rp;
    assign empty_n = st_q.empty_n;
    assign full_n  = st_q.full_n;
    assign half_n  = st_q.half_n;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_stb && !rd_stb) |=> $stable(wr_addr));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_stb) |=> $stable(rd_addr));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    assert_half_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_n && !rd_stb && !rt_stb) |=> !half_n);

    assert_rewind_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_stb && !wr_stb && !rd_stb) |=> (rd_addr == '0));

    assert_rewind_wr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_stb && !wr_stb && !rd_stb) |=> $stable(wr_addr));

endmodule

// File: rtl/strobe_fifo_out.sv
module strobe_fifo_out #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_oe
);

    typedef struct packed {
        logic             oe;
        logic [WIDTH-1:0] data;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d.oe   = rd_en;
        o_d.data = rd_en ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rd_oe   = o_q.oe;
    assign rd_data = o_q.data;

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_stb,
    input  logic             rt_stb,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_oe,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n
);

    logic             wr_en, rd_en;
    logic [AW-1:0]    wr_addr, rd_addr;
    logic [WIDTH-1:0] rd_word;

    strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .rt_stb  (rt_stb),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    strobe_fifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    strobe_fifo_out #(.WIDTH(WIDTH)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    assert_oe_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(rd_stb));

    assert_oe_needs_stock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !empty_n) |=> !rd_oe);

endmodule

// File: tb/sim_strobe_fifo.sv
`timescale 1ns/1ps
module sim_strobe_fifo;

    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, rt_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       rd_oe, empty_n, full_n, half_n;

    strobe_fifo #(.DEPTH(DEPTH), .WIDTH(9)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rt_stb(rt_stb), .rd_data(rd_data), .rd_oe(rd_oe),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [8:0] m_mem [DEPTH];
    int         m_wp, m_rp, m_cnt;
    bit         m_half_n, m_oe;
    logic [8:0] m_data;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_wp = 0; m_rp = 0; m_cnt = 0;
        m_half_n = 1'b1; m_oe = 1'b0; m_data = '0;
    endtask

    task automatic compare_all();
        chk("R5 empty_n", int'(empty_n), int'(m_cnt != 0));
        chk("R5 full_n",  int'(full_n),  int'(m_cnt != DEPTH));
        chk("R6 half_n",  int'(half_n),  int'(m_half_n));
        chk("R9 rd_oe",   int'(rd_oe),   int'(m_oe));
        chk("R1 rd_data", int'(rd_data), int'(m_data));
    endtask

    // Drive one cycle of strobes at a falling edge, update the model at the
    // rising edge, compare at the next falling edge.
    task automatic step(bit w, bit r, bit rt, logic [8:0] d);
        bit wok, rok, rtok;
        wr_stb = w; rd_stb = r; rt_stb = rt; wr_data = d;
        @(posedge clk);
        wok  = w && (m_cnt != DEPTH);
        rok  = r && (m_cnt != 0);
        rtok = rt && !w && !r;
        m_oe   = rok;
        m_data = rok ? m_mem[m_rp] : 9'd0;
        if (wok) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % DEPTH; end
        if (rok) m_rp = (m_rp + 1) % DEPTH;
        if (rtok) begin
            m_rp = 0; m_cnt = m_wp; m_half_n = !(m_cnt > HALF);
        end else begin
            m_cnt = m_cnt + int'(wok) - int'(rok);
            if (wok && !rok && m_cnt > HALF)  m_half_n = 1'b0;
            if (rok && !wok && m_cnt <= HALF) m_half_n = 1'b1;
        end
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0; rt_stb = 1'b0;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R2 empty_n in reset", int'(empty_n), 0);
        chk("R2 full_n in reset",  int'(full_n),  1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fill(int n, int base);
        for (int i = 0; i < n; i++) step(1, 0, 0, 9'((base + i) & 511));
    endtask

    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();

        // R2: state just after reset release
        do_reset();
        chk("R2 empty_n", int'(empty_n), 0);
        chk("R2 full_n",  int'(full_n),  1);
        chk("R2 half_n",  int'(half_n),  1);
        chk("R2 rd_oe",   int'(rd_oe),   0);

        // R5/R6/R3: fill to full, write once more, drain in order (R1)
        fill(DEPTH, 9'h100);
        chk("R5 full after DEPTH writes", int'(full_n), 0);
        step(1, 0, 0, 9'h0AA);
        chk("R3 full_n stays low", int'(full_n), 0);
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 1, 0, 0);
            chk("R3 R1 word order", int'(rd_data), 9'h100 + i);
        end
        chk("R3 nothing extra stored", int'(empty_n), 0);

        // R4: read while empty, then one word passes through
        step(0, 1, 0, 0);
        chk("R4 no output when empty", int'(rd_oe), 0);
        step(1, 0, 0, 9'h1C3);
        step(0, 1, 0, 0);
        chk("R4 read pointer unmoved", int'(rd_data), 9'h1C3);

        // R11: flow-through from empty
        step(1, 0, 0, 9'h055);
        chk("R11 empty_n rises", int'(empty_n), 1);
        step(0, 1, 0, 0);
        chk("R11 word read", int'(rd_data), 9'h055);
        chk("R11 empty_n falls", int'(empty_n), 0);

        // R10: simultaneous read and write at the half threshold
        do_reset();
        fill(HALF, 9'h010);
        step(1, 1, 0, 9'h020);
        chk("R10 half_n unchanged", int'(half_n), 1);
        step(1, 0, 0, 9'h021);
        chk("R10 occupancy kept", int'(half_n), 0);

        // R7: rewind after partial drain replays from location zero
        do_reset();
        fill(HALF + 1, 9'h040);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
        chk("R7 half released", int'(half_n), 1);
        step(0, 0, 1, 0);
        chk("R7 half re-asserted", int'(half_n), 0);
        for (int i = 0; i <= HALF; i++) begin
            step(0, 1, 0, 0);
            chk("R7 replay word", int'(rd_data), 9'h040 + i);
        end

        // R8: rewind beside a write is ignored
        do_reset();
        fill(2, 9'h080);
        step(0, 1, 0, 0);
        step(1, 0, 1, 9'h082);
        step(0, 1, 0, 0);
        chk("R8 rewind ignored", int'(rd_data), 9'h081);

        // Sweep: every fill level times every strobe combination, then drain
        for (int k = 0; k <= DEPTH; k++) begin
            for (int op = 1; op < 8; op++) begin
                do_reset();
                fill(k, k * 16);
                step(op[0], op[1], op[2], 9'h1F0);
                while (m_cnt != 0) step(0, 1, 0, 0);
            end
        end

        // Pseudo-random mix
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] & lfsr[2], (lfsr[7:3] == 5'd0), 9'(lfsr[12:4]));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule